// File: doc/BRIEF.md
# I2C Controller Status Flag Register

This block holds the status flags of an I2C controller and presents them as one 32-bit word on a small synchronous register port. The protocol engine and the data path report events as one-cycle pulses. The events include an address match, a general call, START, repeated START and STOP conditions, a new command being taken up, the data counter reaching zero, a word finishing, and transmit and receive buffer movements. Each pulse sets or clears one or more flags. The flags do not share a polarity or a clear source. The transmit-underflow flag is active low. The transmit-ready flag comes out of reset at 1. The STOP flag also clears when the interrupt vector is read and returns the STOP code. The register-ready flag sets under rules that depend on the master, repeat and stop settings.

Software reads the word and clears selected flags by writing ones to them. Two reset sources are combined: a system reset, and a module-enable control bit held low. Either one puts every flag at its defined value in the same cycle. When a hardware set and a clear arrive in the same cycle, the set wins.

Top module: `i2c_stat_reg`

## Requirements
- R1: When `rst` is high or `mod_en` is low at a clock edge, the status word becomes 0x00000410: bit 10 = 1, bit 4 = 1, all other bits 0. The transmit-reload tracker is also emptied.
- R2: Bits 31..11, 7, 6, 1 and 0 always read 0. A write of 1 clears only bits 5, 4, 3 and 2. Ones written to bits 10, 9 and 8 have no effect.
- R3: Bit 10 (active-low underflow) goes to 0 on `ev_tx_empty` if `ev_tx_write` has not pulsed since the last `ev_tx_copy` (or since reset). It returns to 1 on `ev_tx_write`.
- R4: Bit 9 (addressed as target) sets on `ev_own_addr`, `ev_gcall` or `ev_fdf_first`. It clears on `ev_rstart` or `ev_stop`, and a plain `ev_start` leaves it unchanged.
- R5: Bit 8 (general call) sets on `ev_gcall` and clears on `ev_start`, `ev_rstart` or `ev_stop`.
- R6: Bit 5 (STOP seen) sets on `ev_stop`. It clears on a write of 1, or when `vec_rd` is high with `vec_code` = 3'b110. `vec_rd` with any other code leaves it unchanged.
- R7: Bit 4 (transmit ready) sets on `ev_tx_copy` and clears on `ev_tx_write` or a write of 1.
- R8: Bit 3 (receive ready) sets on `ev_rx_fill` and clears on `ev_rx_read` or a write of 1.
- R9: Bit 2 (register ready) sets when `master` is 1 and either `rpt_mode`=1 with `ev_word_done`, or `rpt_mode`=0, `stp_mode`=0 with `ev_cnt_zero`. In every other case it keeps its value. It clears on `ev_cmd_start` or a write of 1.
- R10: A set event in the same cycle as any clear source for the same flag leaves the flag at its set value.
- R11: A read at `STAT_ADDR` returns, on `reg_rdata` one cycle later, the word as it stood before that edge. A read at any other address returns 0. A write at any other address changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | System reset, synchronous, active high |
| mod_en | input | 1 | Module-enable control bit; 0 holds the flags in reset |
| reg_addr | input | ADDR_W | Register port word address |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 32 | Write data; ones clear flags |
| reg_rdata | output | 32 | Registered read data |
| vec_rd | input | 1 | Interrupt-vector read strobe |
| vec_code | input | 3 | Code returned by that vector read |
| ev_own_addr | input | 1 | Own target address recognised |
| ev_gcall | input | 1 | All-zeros general-call address recognised |
| ev_fdf_first | input | 1 | First word received in free data format |
| ev_start | input | 1 | START condition |
| ev_rstart | input | 1 | Repeated START condition |
| ev_stop | input | 1 | STOP condition on the bus |
| ev_cmd_start | input | 1 | Engine takes up newly programmed values |
| ev_cnt_zero | input | 1 | Data counter reached zero |
| ev_word_done | input | 1 | A transmitted data word ended |
| master | input | 1 | Controller is bus master |
| rpt_mode | input | 1 | Repeat mode selected |
| stp_mode | input | 1 | STOP-at-count-zero selected |
| ev_tx_write | input | 1 | Transmit data register written |
| ev_tx_copy | input | 1 | Transmit data copied to shift register |
| ev_tx_empty | input | 1 | Transmit shift register ran empty |
| ev_rx_fill | input | 1 | Receive data register filled |
| ev_rx_read | input | 1 | Receive data register read |

## Verification
The hardest state to reach is the register-ready flag being left untouched. Stop mode with the counter at zero must leave it alone whether it was 0 or 1. The bench sweeps all 32 combinations of master, repeat, stop, counter-zero and word-done twice: once with the flag first cleared, and once with it first set through a repeat-mode word end. The underflow flag depends on hidden reload history. The bench walks that history through write, copy and empty sequences. It then checks each same-cycle collision of a set with a clear.

// File: rtl/i2c_stat_pkg.sv
package i2c_stat_pkg;

    localparam int WORD_W = 32;
    localparam int NFLAG  = 7;
    localparam int IDX_W  = $clog2(NFLAG);

    // flag slot indices (storage order, not bit order)
    localparam int I_ARDY = 0;
    localparam int I_RRDY = 1;
    localparam int I_XRDY = 2;
    localparam int I_SCD  = 3;
    localparam int I_AD0  = 4;
    localparam int I_AAS  = 5;
    localparam int I_XEMP = 6;

    // value taken by each slot on either reset source
    localparam logic [NFLAG-1:0] FLAG_RST = 7'b100_0100;
    // slots software may clear by writing 1
    localparam logic [NFLAG-1:0] FLAG_W1C = 7'b000_1111;

    localparam logic [2:0] VEC_STOP = 3'b110;

    typedef struct packed {
        logic own_addr;
        logic gcall;
        logic fdf_first;
        logic start;
        logic rstart;
        logic stop;
        logic cmd_start;
        logic cnt_zero;
        logic word_done;
    } proto_ev_t;

    typedef struct packed {
        logic tx_write;
        logic tx_copy;
        logic tx_empty;
        logic rx_fill;
        logic rx_read;
    } data_ev_t;

    typedef struct packed {
        logic master;
        logic rpt;
        logic stp;
    } mode_t;

    // bit position of each slot in the status word
    function automatic int flag_pos(input int idx);
        case (idx)
            I_ARDY:  return 2;
            I_RRDY:  return 3;
            I_XRDY:  return 4;
            I_SCD:   return 5;
            I_AD0:   return 8;
            I_AAS:   return 9;
            default: return 10;
        endcase
    endfunction

    function automatic logic [WORD_W-1:0] pack_flags(input logic [NFLAG-1:0] f);
        logic [WORD_W-1:0] w;
        w = '0;
        for (int i = 0; i < NFLAG; i++) begin
            w[flag_pos(i)] = f[i];
        end
        return w;
    endfunction

endpackage

// File: rtl/i2c_stat_flag.sv
module i2c_stat_flag #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic srst,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);

    always_ff @(posedge clk) begin
        if (srst) begin
            q_o <= RST_VAL;
        end else if (set_i) begin
            q_o <= 1'b1;
        end else if (clr_i) begin
            q_o <= 1'b0;
        end
    end

endmodule

// File: rtl/i2c_stat_events.sv
module i2c_stat_events
    import i2c_stat_pkg::*;
(
    input  logic             clk,
    input  logic             srst,
    input  proto_ev_t        pev,
    input  data_ev_t         dev,
    input  mode_t            md,
    input  logic             vec_rd,
    input  logic [2:0]       vec_code,
    output logic [NFLAG-1:0] hw_set,
    output logic [NFLAG-1:0] hw_clr
);

    // remembers whether the transmit data register holds unsent data
    logic tx_loaded_q;

    always_ff @(posedge clk) begin
        if (srst) begin
            tx_loaded_q <= 1'b0;
        end else if (dev.tx_write) begin
            tx_loaded_q <= 1'b1;
        end else if (dev.tx_copy) begin
            tx_loaded_q <= 1'b0;
        end
    end

    logic ardy_hit;
    logic stop_vec_read;

    always_comb begin
        ardy_hit = 1'b0;
        if (md.master) begin
            if (md.rpt) begin
                ardy_hit = pev.word_done;
            end else if (!md.stp) begin
                ardy_hit = pev.cnt_zero;
            end
        end
    end

    assign stop_vec_read = vec_rd && (vec_code == VEC_STOP);

    always_comb begin
        hw_set = '0;
        hw_clr = '0;

        hw_set[I_ARDY] = ardy_hit;
        hw_clr[I_ARDY] = pev.cmd_start;

        hw_set[I_RRDY] = dev.rx_fill;
        hw_clr[I_RRDY] = dev.rx_read;

        hw_set[I_XRDY] = dev.tx_copy;
        hw_clr[I_XRDY] = dev.tx_write;

        hw_set[I_SCD]  = pev.stop;
        hw_clr[I_SCD]  = stop_vec_read;

        hw_set[I_AD0]  = pev.gcall;
        hw_clr[I_AD0]  = pev.start | pev.rstart | pev.stop;

        hw_set[I_AAS]  = pev.own_addr | pev.gcall | pev.fdf_first;
        hw_clr[I_AAS]  = pev.rstart | pev.stop;

        // active-low flag: "set" restores the no-underflow level
        hw_set[I_XEMP] = dev.tx_write;
        hw_clr[I_XEMP] = dev.tx_empty & ~tx_loaded_q;
    end

endmodule

// File: rtl/i2c_stat_bus.sv
module i2c_stat_bus
    import i2c_stat_pkg::*;
#(
    parameter int               ADDR_W    = 4,
    parameter logic [ADDR_W-1:0] STAT_ADDR = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [WORD_W-1:0] reg_wdata,
    input  logic [WORD_W-1:0] stat_word,
    output logic [NFLAG-1:0]  w1c_hit,
    output logic [WORD_W-1:0] reg_rdata
);

    logic addr_hit;
    assign addr_hit = (reg_addr == STAT_ADDR);

    for (genvar i = 0; i < NFLAG; i++) begin : g_w1c
        if (FLAG_W1C[i]) begin : g_on
            assign w1c_hit[i] = reg_wr && addr_hit && reg_wdata[flag_pos(i)];
        end else begin : g_off
            assign w1c_hit[i] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            reg_rdata <= '0;
        end else if (reg_rd) begin
            reg_rdata <= addr_hit ? stat_word : '0;
        end
    end

endmodule

// File: rtl/i2c_stat_reg.sv
module i2c_stat_reg
    import i2c_stat_pkg::*;
#(
    parameter int                ADDR_W    = 4,
    parameter logic [ADDR_W-1:0] STAT_ADDR = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mod_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              vec_rd,
    input  logic [2:0]        vec_code,
    input  logic              ev_own_addr,
    input  logic              ev_gcall,
    input  logic              ev_fdf_first,
    input  logic              ev_start,
    input  logic              ev_rstart,
    input  logic              ev_stop,
    input  logic              ev_cmd_start,
    input  logic              ev_cnt_zero,
    input  logic              ev_word_done,
    input  logic              master,
    input  logic              rpt_mode,
    input  logic              stp_mode,
    input  logic              ev_tx_write,
    input  logic              ev_tx_copy,
    input  logic              ev_tx_empty,
    input  logic              ev_rx_fill,
    input  logic              ev_rx_read
);

    logic             srst;
    proto_ev_t        pev;
    data_ev_t         dev;
    mode_t            md;
    logic [NFLAG-1:0] hw_set;
    logic [NFLAG-1:0] hw_clr;
    logic [NFLAG-1:0] w1c_hit;
    logic [NFLAG-1:0] flags;
    logic [WORD_W-1:0] stat_word;

    assign srst = rst | ~mod_en;

    assign pev = '{own_addr:  ev_own_addr,
                   gcall:     ev_gcall,
                   fdf_first: ev_fdf_first,
                   start:     ev_start,
                   rstart:    ev_rstart,
                   stop:      ev_stop,
                   cmd_start: ev_cmd_start,
                   cnt_zero:  ev_cnt_zero,
                   word_done: ev_word_done};

    assign dev = '{tx_write: ev_tx_write,
                   tx_copy:  ev_tx_copy,
                   tx_empty: ev_tx_empty,
                   rx_fill:  ev_rx_fill,
                   rx_read:  ev_rx_read};

    assign md = '{master: master, rpt: rpt_mode, stp: stp_mode};

    i2c_stat_events u_events (
        .clk      (clk),
        .srst     (srst),
        .pev      (pev),
        .dev      (dev),
        .md       (md),
        .vec_rd   (vec_rd),
        .vec_code (vec_code),
        .hw_set   (hw_set),
        .hw_clr   (hw_clr)
    );

    for (genvar i = 0; i < NFLAG; i++) begin : g_flag
        i2c_stat_flag #(
            .RST_VAL (FLAG_RST[i])
        ) u_flag (
            .clk   (clk),
            .srst  (srst),
            .set_i (hw_set[i]),
            .clr_i (hw_clr[i] | w1c_hit[i]),
            .q_o   (flags[i])
        );
    end

    assign stat_word = pack_flags(flags);

    i2c_stat_bus #(
        .ADDR_W    (ADDR_W),
        .STAT_ADDR (STAT_ADDR)
    ) u_bus (
        .clk       (clk),
        .rst       (rst),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_wdata (reg_wdata),
        .stat_word (stat_word),
        .w1c_hit   (w1c_hit),
        .reg_rdata (reg_rdata)
    );

endmodule

// File: rtl/i2c_stat_reg_chk.sv
module i2c_stat_reg_chk (
    input logic        clk,
    input logic        rst,
    input logic        mod_en,
    input logic [31:0] stat_word,
    input logic [6:0]  w1c_hit,
    input logic        ev_stop,
    input logic        ev_rstart,
    input logic        ev_own_addr,
    input logic        ev_gcall,
    input logic        ev_fdf_first,
    input logic        ev_tx_write,
    input logic        ev_tx_copy,
    input logic        ev_rx_fill,
    input logic        ev_cmd_start,
    input logic        ev_cnt_zero,
    input logic        ev_word_done,
    input logic        master,
    input logic        rpt_mode,
    input logic        stp_mode
);

    p_modrst_vals_r1: assert property (@(posedge clk) disable iff (rst)
        !mod_en |=> (stat_word == 32'h0000_0410));

    p_xemp_reload_r3: assert property (@(posedge clk) disable iff (rst)
        (mod_en && ev_tx_write) |=> stat_word[10]);

    p_aas_drop_r4: assert property (@(posedge clk) disable iff (rst)
        (mod_en && ev_stop && !ev_own_addr && !ev_gcall && !ev_fdf_first) |=> !stat_word[9]);

    p_ad0_drop_r5: assert property (@(posedge clk) disable iff (rst)
        (mod_en && ev_rstart && !ev_gcall) |=> !stat_word[8]);

    p_scd_catch_r6: assert property (@(posedge clk) disable iff (rst)
        (mod_en && ev_stop) |=> stat_word[5]);

    p_xrdy_drop_r7: assert property (@(posedge clk) disable iff (rst)
        (mod_en && ev_tx_write && !ev_tx_copy) |=> !stat_word[4]);

    p_ardy_keep_r9: assert property (@(posedge clk) disable iff (rst)
        (mod_en && master && !rpt_mode && stp_mode && !ev_cmd_start && !w1c_hit[0])
        |=> (stat_word[2] == $past(stat_word[2])));

    p_set_wins_r10: assert property (@(posedge clk) disable iff (rst)
        (mod_en && ev_rx_fill && w1c_hit[1]) |=> stat_word[3]);

    p_word_unused_r2: assert property (@(posedge clk) disable iff (rst)
        mod_en |=> ((stat_word & 32'hFFFF_F8C3) == 32'h0));

    // the set conditions are unused by the checks above in one direction only
    logic unused_inputs;
    assign unused_inputs = ev_cnt_zero ^ ev_word_done;

endmodule

bind i2c_stat_reg i2c_stat_reg_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .mod_en       (mod_en),
    .stat_word    (stat_word),
    .w1c_hit      (w1c_hit),
    .ev_stop      (ev_stop),
    .ev_rstart    (ev_rstart),
    .ev_own_addr  (ev_own_addr),
    .ev_gcall     (ev_gcall),
    .ev_fdf_first (ev_fdf_first),
    .ev_tx_write  (ev_tx_write),
    .ev_tx_copy   (ev_tx_copy),
    .ev_rx_fill   (ev_rx_fill),
    .ev_cmd_start (ev_cmd_start),
    .ev_cnt_zero  (ev_cnt_zero),
    .ev_word_done (ev_word_done),
    .master       (master),
    .rpt_mode     (rpt_mode),
    .stp_mode     (stp_mode)
);

// File: tb/i2c_stat_reg_tb.sv
module i2c_stat_reg_tb;

    localparam int           ADDR_W = 4;
    localparam logic [3:0]   STAT   = 4'h2;
    localparam time          HALF   = 2.5ns;

    logic clk = 1'b0;
    always #(HALF) clk = ~clk;

    logic        rst, mod_en, reg_wr, reg_rd, vec_rd;
    logic [3:0]  reg_addr;
    logic [31:0] reg_wdata, reg_rdata;
    logic [2:0]  vec_code;
    logic ev_own_addr, ev_gcall, ev_fdf_first, ev_start, ev_rstart, ev_stop;
    logic ev_cmd_start, ev_cnt_zero, ev_word_done, master, rpt_mode, stp_mode;
    logic ev_tx_write, ev_tx_copy, ev_tx_empty, ev_rx_fill, ev_rx_read;

    int total = 0;
    int bad   = 0;

    i2c_stat_reg #(.ADDR_W(ADDR_W), .STAT_ADDR(STAT)) u_dut (
        .clk(clk), .rst(rst), .mod_en(mod_en), .reg_addr(reg_addr),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .vec_rd(vec_rd), .vec_code(vec_code), .ev_own_addr(ev_own_addr),
        .ev_gcall(ev_gcall), .ev_fdf_first(ev_fdf_first), .ev_start(ev_start),
        .ev_rstart(ev_rstart), .ev_stop(ev_stop), .ev_cmd_start(ev_cmd_start),
        .ev_cnt_zero(ev_cnt_zero), .ev_word_done(ev_word_done), .master(master),
        .rpt_mode(rpt_mode), .stp_mode(stp_mode), .ev_tx_write(ev_tx_write),
        .ev_tx_copy(ev_tx_copy), .ev_tx_empty(ev_tx_empty), .ev_rx_fill(ev_rx_fill),
        .ev_rx_read(ev_rx_read)
    );

    task automatic step();
        @(negedge clk);
    endtask

    task automatic quiet();
        reg_wr = 0; reg_rd = 0; vec_rd = 0; vec_code = 0; reg_addr = STAT; reg_wdata = 0;
        ev_own_addr = 0; ev_gcall = 0; ev_fdf_first = 0; ev_start = 0; ev_rstart = 0;
        ev_stop = 0; ev_cmd_start = 0; ev_cnt_zero = 0; ev_word_done = 0;
        master = 0; rpt_mode = 0; stp_mode = 0;
        ev_tx_write = 0; ev_tx_copy = 0; ev_tx_empty = 0; ev_rx_fill = 0; ev_rx_read = 0;
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd_word(output logic [31:0] v);
        reg_addr = STAT; reg_rd = 1;
        step();
        reg_rd = 0;
        v = reg_rdata;
    endtask

    task automatic chk_bit(input string tag, input int pos, input logic exp);
        logic [31:0] v;
        rd_word(v);
        check(tag, {31'b0, v[pos]}, {31'b0, exp});
    endtask

    task automatic w1c(input logic [31:0] m);
        reg_addr = STAT; reg_wr = 1; reg_wdata = m;
        step();
        reg_wr = 0; reg_wdata = 0;
    endtask

    initial begin
        #(HALF * 2 * 100000);
        total++; bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        quiet();
        rst = 1; mod_en = 1;
        step(); step(); step();
        rst = 0;
        step();

        // R1 system reset values
        rd_word(v);
        check("R1 after rst", v, 32'h0000_0410);

        // R1 module-enable reset from a busy state
        ev_rx_fill = 1; ev_stop = 1; ev_gcall = 1; ev_tx_write = 1; step(); quiet();
        mod_en = 0; step(); mod_en = 1;
        rd_word(v);
        check("R1 after mod_en low", v, 32'h0000_0410);

        // R2 write all ones: only 5..2 may clear
        ev_gcall = 1; step(); quiet();
        rd_word(v);
        check("R2 before write", v, 32'h0000_0710);
        w1c(32'hFFFF_FFFF);
        rd_word(v);
        check("R2 after all-ones write", v, 32'h0000_0700);

        // R11 write and read at another address
        ev_rx_fill = 1; step(); quiet();
        reg_addr = 4'h5; reg_wr = 1; reg_wdata = 32'hFFFF_FFFF; step(); quiet();
        rd_word(v);
        check("R11 foreign write ignored", v, 32'h0000_0708);
        reg_addr = 4'h5; reg_rd = 1; step(); v = reg_rdata; quiet();
        check("R11 foreign read zero", v, 32'h0);

        // R11 read sees pre-edge value
        w1c(32'h8);
        ev_rx_fill = 1; reg_rd = 1; reg_addr = STAT; step(); v = reg_rdata; quiet();
        check("R11 read before same-edge set", {31'b0, v[3]}, 32'h0);
        chk_bit("R11 read after set", 3, 1'b1);

        // R3 underflow history
        rst = 1; step(); rst = 0;
        ev_tx_empty = 1; step(); quiet();
        chk_bit("R3 empty with no reload", 10, 1'b0);
        ev_tx_write = 1; step(); quiet();
        chk_bit("R3 restored by write", 10, 1'b1);
        ev_tx_empty = 1; step(); quiet();
        chk_bit("R3 empty while loaded", 10, 1'b1);
        ev_tx_copy = 1; step(); quiet();
        ev_tx_empty = 1; step(); quiet();
        chk_bit("R3 empty after copy", 10, 1'b0);
        ev_tx_write = 1; ev_tx_empty = 1; step(); quiet();
        chk_bit("R3 write beats underflow R10", 10, 1'b1);

        // R4 addressed flag
        ev_own_addr = 1; step(); quiet();
        chk_bit("R4 own address", 9, 1'b1);
        ev_start = 1; step(); quiet();
        chk_bit("R4 plain start keeps", 9, 1'b1);
        ev_rstart = 1; step(); quiet();
        chk_bit("R4 repeated start clears", 9, 1'b0);
        ev_fdf_first = 1; step(); quiet();
        chk_bit("R4 free format", 9, 1'b1);
        ev_stop = 1; step(); quiet();
        chk_bit("R4 stop clears", 9, 1'b0);

        // R5 general call flag
        for (int k = 0; k < 3; k++) begin
            ev_gcall = 1; step(); quiet();
            chk_bit("R5 gcall sets", 8, 1'b1);
            chk_bit("R5 gcall also R4", 9, 1'b1);
            if (k == 0) ev_start = 1; else if (k == 1) ev_rstart = 1; else ev_stop = 1;
            step(); quiet();
            chk_bit("R5 condition clears", 8, 1'b0);
        end

        // R6 vector code sweep
        for (int c = 0; c < 8; c++) begin
            ev_stop = 1; step(); quiet();
            vec_rd = 1; vec_code = 3'(c); step(); quiet();
            chk_bit("R6 vector read", 5, (c != 6));
        end
        ev_stop = 1; step(); quiet();
        vec_code = 3'b110; step(); quiet();
        chk_bit("R6 code without strobe", 5, 1'b1);
        w1c(32'h20);
        chk_bit("R6 write one", 5, 1'b0);
        ev_stop = 1; vec_rd = 1; vec_code = 3'b110; step(); quiet();
        chk_bit("R10 stop beats vector clear", 5, 1'b1);

        // R7 transmit ready
        rst = 1; step(); rst = 0;
        chk_bit("R7 reset high", 4, 1'b1);
        ev_tx_write = 1; step(); quiet();
        chk_bit("R7 write clears", 4, 1'b0);
        ev_tx_copy = 1; step(); quiet();
        chk_bit("R7 copy sets", 4, 1'b1);
        w1c(32'h10);
        chk_bit("R7 write one", 4, 1'b0);
        ev_tx_copy = 1; ev_tx_write = 1; step(); quiet();
        chk_bit("R10 copy beats write", 4, 1'b1);

        // R8 receive ready
        ev_rx_fill = 1; step(); quiet();
        chk_bit("R8 fill sets", 3, 1'b1);
        ev_rx_read = 1; step(); quiet();
        chk_bit("R8 read clears", 3, 1'b0);
        ev_rx_fill = 1; step(); quiet();
        w1c(32'h8);
        chk_bit("R8 write one", 3, 1'b0);
        ev_rx_fill = 1; reg_wr = 1; reg_wdata = 32'h8; step(); quiet();
        chk_bit("R10 fill beats write one", 3, 1'b1);

        // R9 mode sweep, starting clear then starting set
        for (int pre = 0; pre < 2; pre++) begin
            for (int m = 0; m < 32; m++) begin
                logic setx, expv;
                w1c(32'h4);
                if (pre == 1) begin
                    master = 1; rpt_mode = 1; ev_word_done = 1; step(); quiet();
                end
                master = m[4]; rpt_mode = m[3]; stp_mode = m[2];
                ev_cnt_zero = m[1]; ev_word_done = m[0];
                step(); quiet();
                setx = m[4] && (m[3] ? m[0] : (!m[2] && m[1]));
                expv = (pre == 1) || setx;
                chk_bit($sformatf("R9 pre=%0d mode=%0d", pre, m), 2, expv);
            end
        end
        master = 1; rpt_mode = 1; ev_word_done = 1; step(); quiet();
        ev_cmd_start = 1; step(); quiet();
        chk_bit("R9 command start clears", 2, 1'b0);
        master = 1; ev_cnt_zero = 1; ev_cmd_start = 1; step(); quiet();
        chk_bit("R10 count zero beats command start", 2, 1'b1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule